// File: doc/BRIEF.md
# Fetch Stage Status Controller

This block is the cycle-level control state machine of an out-of-order processor's instruction fetch stage. Each cycle it weighs these inputs and picks one of six states:
- squash requests from the commit and decode stages;
- a hold asserted while the reorder buffer is still flushing;
- stall flags from four downstream stages;
- the outcome of the fetch stage's own instruction-cache access.

It tells the fetch datapath three things for the current cycle: whether fetching is permitted, whether a fresh cache access is launched, and whether a group of instructions is handed to decode.

A squash redirects the program counter. The redirect pulse appears one cycle after the squash, carrying the new PC and the sequential next PC. A squash that carries a mispredict also emits a one-cycle update for the direction predictor and the branch target buffer. A pending cache miss is tracked through a stall state and a completion state. A completion pulse is honoured only while a miss is outstanding. A squash that cancels an outstanding miss raises a one-cycle cancel strobe toward the cache.

Decisions are evaluated in a fixed order:
1. commit squash;
2. reorder-buffer hold;
3. decode squash;
4. stalls;
5. state-specific work.

The status register, redirect outputs and predictor update outputs are registered. The three per-cycle strobes are combinational from the current state and inputs.

Top module: `fetch_status_ctrl`

## Requirements
- R1: A synchronous active-low reset puts `status` in Idle and clears every registered pulse. The 3-bit `status` codes are: Idle=0, Running=1, Blocked=2, Squashing=3, MissStall=4, MissComplete=5.
- R2: A commit squash, in any state, moves `status` to Squashing at the next edge and holds `fetch_en` low in that cycle. In the following cycle `redir_valid` is 1, `redir_pc` equals the commit redirect address and `redir_npc` equals that address plus INST_BYTES.
- R3: A commit squash with its mispredict flag set produces, one cycle later, both predictor update pulses. Both carry the commit mispredicted PC. The direction update carries the commit taken bit, and the target update carries the commit redirect address as the target.
- R4: With no commit squash, a high `rob_squashing` moves `status` to Squashing, holds `fetch_en` low and produces no redirect.
- R5: A decode squash whose mispredict flag is set requests a predictor update with the decode fields, in any state. The decode squash redirects and enters Squashing only when the current state is not Squashing. Otherwise evaluation continues to the stall check.
- R6: When no squash takes effect and any of the four stall inputs is high, `status` becomes Blocked whatever the current state, with `fetch_en` low.
- R7: From Blocked with no stall, and from Squashing with no squash input, `status` moves to Running and `fetch_en` stays low in that cycle.
- R8: `miss_done` moves MissStall to MissComplete. In any other state it has no effect on `status`.
- R9: In MissStall `fetch_en` is low. In MissComplete, `fetch_en` and `deliver` are high, `acc_req` is low, and the next state is Running.
- R10: In Idle or Running with nothing of higher priority pending, `fetch_en` and `acc_req` are high. Then `acc_fault` leads to Blocked; otherwise `acc_miss` leads to MissStall with `deliver` low; otherwise the state becomes Running with `deliver` high.
- R11: A squash that redirects while `status` is MissStall raises `miss_cancel` for exactly the following cycle.
- R12: When commit and decode squash together, only the commit redirect and the commit predictor update take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmt_squash | input | 1 | Squash request from commit |
| cmt_redirect_pc | input | ADDR_W | Commit redirect address |
| cmt_mispredict | input | 1 | Commit squash stems from a branch mispredict |
| cmt_mispred_pc | input | ADDR_W | PC of the mispredicted branch (commit) |
| cmt_taken | input | 1 | Resolved direction of that branch (commit) |
| rob_squashing | input | 1 | Reorder buffer still flushing |
| dec_squash | input | 1 | Squash request from decode |
| dec_redirect_pc | input | ADDR_W | Decode redirect address |
| dec_mispredict | input | 1 | Decode squash stems from a mispredict |
| dec_mispred_pc | input | ADDR_W | PC of the mispredicted branch (decode) |
| dec_taken | input | 1 | Resolved direction (decode) |
| stall_decode | input | 1 | Stall from decode |
| stall_rename | input | 1 | Stall from rename |
| stall_exec | input | 1 | Stall from issue/execute |
| stall_commit | input | 1 | Stall from commit |
| acc_miss | input | 1 | This cycle's cache access missed |
| acc_fault | input | 1 | This cycle's fetch faulted |
| miss_done | input | 1 | Miss completion pulse from the cache |
| status | output | 3 | Current state code |
| fetch_en | output | 1 | Fetch permitted this cycle |
| acc_req | output | 1 | New cache access launched this cycle |
| deliver | output | 1 | Instructions handed to decode this cycle |
| redir_valid | output | 1 | PC redirect pulse |
| redir_pc | output | ADDR_W | New PC |
| redir_npc | output | ADDR_W | New PC plus one instruction |
| miss_cancel | output | 1 | Cancel the outstanding cache miss |
| upd_dir_valid | output | 1 | Direction predictor update pulse |
| upd_dir_pc | output | ADDR_W | Branch PC for the direction update |
| upd_dir_taken | output | 1 | Taken outcome for the direction update |
| upd_tgt_valid | output | 1 | Target buffer update pulse |
| upd_tgt_pc | output | ADDR_W | Branch PC for the target update |
| upd_tgt_addr | output | ADDR_W | Target written to the target buffer |

## Verification
The bench drives the design into each of the six states and, from there, applies every combination of squash, mispredict, hold, stall, completion, miss and fault inputs. Each state and input combination is checked against expectations worked out from the priority order.

A decode squash arriving while already in Squashing must still update the predictor but must fall through to the stall check. A design that redirected again would emit a spurious `redir_valid`. A late `miss_done` in Blocked or Running must leave the state untouched; a design that took it would jump to MissComplete and deliver stale instructions.

A simultaneous commit and decode squash exposes a design that lets the decode redirect or update win, because the two sources use distinct addresses and taken bits. Squashes out of MissStall must pulse `miss_cancel`; a design that omits it lets an old completion wake a later miss.

// File: rtl/fsc_pkg.sv
// Package: shared state and source encodings for the fetch status controller.
// Assumes: the state codes are visible on the status port and are decoded
// by neighbouring logic, so their values are fixed.
package fsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_BLOCK  = 3'd2,
        ST_SQUASH = 3'd3,
        ST_MSTALL = 3'd4,
        ST_MDONE  = 3'd5
    } fetch_state_e;

    // Which stage, if any, supplies a redirect or a predictor update.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_COMMIT = 2'd1,
        SRC_DECODE = 2'd2
    } src_sel_e;

endpackage

// File: rtl/fsc_arbiter.sv
// Module: fsc_arbiter
// Purely combinational priority evaluator. It takes the current state and
// this cycle's control inputs and returns the next state, the per-cycle
// fetch strobes, the redirect and update sources and the miss-cancel request.
// Assumes: acc_miss and acc_fault describe the access launched in this same
// cycle and are only meaningful while acc_req is high.
module fsc_arbiter
    import fsc_pkg::*;
(
    input  fetch_state_e cur_state,
    input  logic         cmt_squash,
    input  logic         cmt_mispredict,
    input  logic         rob_squashing,
    input  logic         dec_squash,
    input  logic         dec_mispredict,
    input  logic         any_stall,
    input  logic         acc_miss,
    input  logic         acc_fault,
    input  logic         miss_done,
    output fetch_state_e nxt_state,
    output logic         fetch_en,
    output logic         acc_req,
    output logic         deliver,
    output src_sel_e     redir_src,
    output src_sel_e     upd_src,
    output logic         cancel_req
);

    // Fixed-priority decision: commit squash, ROB hold, decode squash,
    // stalls, then per-state work.
    always_comb begin
        nxt_state  = cur_state;
        fetch_en   = 1'b0;
        acc_req    = 1'b0;
        deliver    = 1'b0;
        redir_src  = SRC_NONE;
        upd_src    = SRC_NONE;
        cancel_req = 1'b0;
        if (cmt_squash) begin
            nxt_state  = ST_SQUASH;
            redir_src  = SRC_COMMIT;
            cancel_req = (cur_state == ST_MSTALL);
            if (cmt_mispredict) begin
                upd_src = SRC_COMMIT;
            end
        end else if (rob_squashing) begin
            nxt_state = ST_SQUASH;
        end else begin
            if (dec_squash && dec_mispredict) begin
                upd_src = SRC_DECODE;
            end
            if (dec_squash && (cur_state != ST_SQUASH)) begin
                nxt_state  = ST_SQUASH;
                redir_src  = SRC_DECODE;
                cancel_req = (cur_state == ST_MSTALL);
            end else if (any_stall) begin
                nxt_state = ST_BLOCK;
            end else begin
                case (cur_state)
                    ST_BLOCK, ST_SQUASH: begin
                        nxt_state = ST_RUN;
                    end
                    ST_MSTALL: begin
                        if (miss_done) begin
                            nxt_state = ST_MDONE;
                        end
                    end
                    ST_MDONE: begin
                        fetch_en  = 1'b1;
                        deliver   = 1'b1;
                        nxt_state = ST_RUN;
                    end
                    default: begin
                        fetch_en = 1'b1;
                        acc_req  = 1'b1;
                        if (acc_fault) begin
                            nxt_state = ST_BLOCK;
                        end else if (acc_miss) begin
                            nxt_state = ST_MSTALL;
                        end else begin
                            nxt_state = ST_RUN;
                            deliver   = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/fsc_redirect.sv
// Module: fsc_redirect
// Registers the PC redirect selected by the arbiter and the miss-cancel
// strobe, so that each appears as a one-cycle pulse after the squash.
// Assumes: INST_BYTES is the fixed instruction size in bytes.
module fsc_redirect
    import fsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_sel_e          redir_src,
    input  logic              cancel_req,
    input  logic [ADDR_W-1:0] cmt_pc,
    input  logic [ADDR_W-1:0] dec_pc,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_pc,
    output logic [ADDR_W-1:0] redir_npc,
    output logic              miss_cancel
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

    logic [ADDR_W-1:0] sel_pc;

    // Pick the redirect address of the winning squash source.
    always_comb begin
        sel_pc = (redir_src == SRC_DECODE) ? dec_pc : cmt_pc;
    end

    // Register the redirect pulse, both PCs and the cancel strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            redir_npc   <= '0;
            miss_cancel <= 1'b0;
        end else begin
            redir_valid <= (redir_src != SRC_NONE);
            miss_cancel <= cancel_req;
            if (redir_src != SRC_NONE) begin
                redir_pc  <= sel_pc;
                redir_npc <= sel_pc + STEP;
            end
        end
    end

endmodule

// File: rtl/fsc_pred_update.sv
// Module: fsc_pred_update
// Registers the predictor training request chosen by the arbiter: one
// direction update and one target-buffer update, both single-cycle pulses.
// Assumes: the target written on a mispredict is the squash redirect address.
module fsc_pred_update
    import fsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_sel_e          upd_src,
    input  logic [ADDR_W-1:0] cmt_mpc,
    input  logic              cmt_taken,
    input  logic [ADDR_W-1:0] cmt_target,
    input  logic [ADDR_W-1:0] dec_mpc,
    input  logic              dec_taken,
    input  logic [ADDR_W-1:0] dec_target,
    output logic              upd_dir_valid,
    output logic [ADDR_W-1:0] upd_dir_pc,
    output logic              upd_dir_taken,
    output logic              upd_tgt_valid,
    output logic [ADDR_W-1:0] upd_tgt_pc,
    output logic [ADDR_W-1:0] upd_tgt_addr
);

    logic              use_dec;
    logic [ADDR_W-1:0] sel_mpc;
    logic [ADDR_W-1:0] sel_tgt;
    logic              sel_tk;

    // Select the fields of the stage that owns this cycle's update.
    always_comb begin
        use_dec = (upd_src == SRC_DECODE);
        sel_mpc = use_dec ? dec_mpc    : cmt_mpc;
        sel_tgt = use_dec ? dec_target : cmt_target;
        sel_tk  = use_dec ? dec_taken  : cmt_taken;
    end

    // Register the two update pulses and their payloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_dir_valid <= 1'b0;
            upd_dir_pc    <= '0;
            upd_dir_taken <= 1'b0;
            upd_tgt_valid <= 1'b0;
            upd_tgt_pc    <= '0;
            upd_tgt_addr  <= '0;
        end else begin
            upd_dir_valid <= (upd_src != SRC_NONE);
            upd_tgt_valid <= (upd_src != SRC_NONE);
            if (upd_src != SRC_NONE) begin
                upd_dir_pc    <= sel_mpc;
                upd_dir_taken <= sel_tk;
                upd_tgt_pc    <= sel_mpc;
                upd_tgt_addr  <= sel_tgt;
            end
        end
    end

endmodule

// File: rtl/fetch_status_ctrl.sv
// Module: fetch_status_ctrl
// Top of the fetch stage status controller. It holds the state register and
// ties together the priority arbiter, the redirect register and the
// predictor update register.
// Assumes: synchronous active-low reset, and a cache access result that
// returns in the same cycle as acc_req.
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmt_squash,
    input  logic [ADDR_W-1:0] cmt_redirect_pc,
    input  logic              cmt_mispredict,
    input  logic [ADDR_W-1:0] cmt_mispred_pc,
    input  logic              cmt_taken,
    input  logic              rob_squashing,
    input  logic              dec_squash,
    input  logic [ADDR_W-1:0] dec_redirect_pc,
    input  logic              dec_mispredict,
    input  logic [ADDR_W-1:0] dec_mispred_pc,
    input  logic              dec_taken,
    input  logic              stall_decode,
    input  logic              stall_rename,
    input  logic              stall_exec,
    input  logic              stall_commit,
    input  logic              acc_miss,
    input  logic              acc_fault,
    input  logic              miss_done,
    output logic [2:0]        status,
    output logic              fetch_en,
    output logic              acc_req,
    output logic              deliver,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_pc,
    output logic [ADDR_W-1:0] redir_npc,
    output logic              miss_cancel,
    output logic              upd_dir_valid,
    output logic [ADDR_W-1:0] upd_dir_pc,
    output logic              upd_dir_taken,
    output logic              upd_tgt_valid,
    output logic [ADDR_W-1:0] upd_tgt_pc,
    output logic [ADDR_W-1:0] upd_tgt_addr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

    fetch_state_e cur_state;
    fetch_state_e nxt_state;
    src_sel_e     redir_src;
    src_sel_e     upd_src;
    logic         cancel_req;
    logic         any_stall;

    // Merge the four downstream stall sources.
    always_comb begin
        any_stall = stall_decode | stall_rename | stall_exec | stall_commit;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_state <= ST_IDLE;
        end else begin
            cur_state <= nxt_state;
        end
    end

    // Expose the state code.
    always_comb begin
        status = cur_state;
    end

    fsc_arbiter arb_i (
        .cur_state      (cur_state),
        .cmt_squash     (cmt_squash),
        .cmt_mispredict (cmt_mispredict),
        .rob_squashing  (rob_squashing),
        .dec_squash     (dec_squash),
        .dec_mispredict (dec_mispredict),
        .any_stall      (any_stall),
        .acc_miss       (acc_miss),
        .acc_fault      (acc_fault),
        .miss_done      (miss_done),
        .nxt_state      (nxt_state),
        .fetch_en       (fetch_en),
        .acc_req        (acc_req),
        .deliver        (deliver),
        .redir_src      (redir_src),
        .upd_src        (upd_src),
        .cancel_req     (cancel_req)
    );

    fsc_redirect #(
        .ADDR_W     (ADDR_W),
        .INST_BYTES (INST_BYTES)
    ) redir_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .redir_src   (redir_src),
        .cancel_req  (cancel_req),
        .cmt_pc      (cmt_redirect_pc),
        .dec_pc      (dec_redirect_pc),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .redir_npc   (redir_npc),
        .miss_cancel (miss_cancel)
    );

    fsc_pred_update #(
        .ADDR_W (ADDR_W)
    ) pred_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .upd_src       (upd_src),
        .cmt_mpc       (cmt_mispred_pc),
        .cmt_taken     (cmt_taken),
        .cmt_target    (cmt_redirect_pc),
        .dec_mpc       (dec_mispred_pc),
        .dec_taken     (dec_taken),
        .dec_target    (dec_redirect_pc),
        .upd_dir_valid (upd_dir_valid),
        .upd_dir_pc    (upd_dir_pc),
        .upd_dir_taken (upd_dir_taken),
        .upd_tgt_valid (upd_tgt_valid),
        .upd_tgt_pc    (upd_tgt_pc),
        .upd_tgt_addr  (upd_tgt_addr)
    );

    AST_CMT_SQ_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |=> (status == 3'd3)); // R2
    AST_CMT_SQ_NOFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |-> !fetch_en); // R2
    AST_CMT_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |=> (redir_valid && redir_pc == $past(cmt_redirect_pc)
                        && redir_npc == $past(cmt_redirect_pc) + STEP)); // R2
    AST_CMT_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_squash && cmt_mispredict) |=> (upd_dir_valid && upd_tgt_valid
                        && upd_tgt_addr == $past(cmt_redirect_pc))); // R3
    AST_ROB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_squashing && !cmt_squash) |=> (status == 3'd3 && !redir_valid)); // R4
    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmt_squash && !rob_squashing && !(dec_squash && status != 3'd3)
         && (stall_decode || stall_rename || stall_exec || stall_commit))
        |=> (status == 3'd2)); // R6
    AST_STALE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 3'd4 && status != 3'd5) |=> (status != 3'd5)); // R8
    AST_MSTALL_NOFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd4) |-> !fetch_en); // R9
    AST_MDONE_NOACC: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd5) |-> !acc_req); // R9
    AST_CANCEL_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cancel |-> ($past(status) == 3'd4 && redir_valid)); // R11

endmodule

// File: tb/fetch_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module fetch_status_ctrl_tb_top;

    localparam int AW = 32;
    localparam int IB = 4;

    localparam logic [AW-1:0] C_PC  = 32'h1000_0100;
    localparam logic [AW-1:0] C_MPC = 32'h3000_0300;
    localparam logic [AW-1:0] D_PC  = 32'h2000_0200;
    localparam logic [AW-1:0] D_MPC = 32'h4000_0400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic c_sq = 0, c_mp = 0, rob = 0, d_sq = 0, d_mp = 0;
    logic s_dec = 0, s_ren = 0, s_exe = 0, s_cmt = 0;
    logic a_miss = 0, a_flt = 0, m_done = 0;
    logic [2:0]    status;
    logic          fetch_en, acc_req, deliver, redir_valid, miss_cancel;
    logic [AW-1:0] redir_pc, redir_npc, upd_dir_pc, upd_tgt_pc, upd_tgt_addr;
    logic          upd_dir_valid, upd_dir_taken, upd_tgt_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    fetch_status_ctrl #(.ADDR_W(AW), .INST_BYTES(IB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmt_squash(c_sq), .cmt_redirect_pc(C_PC), .cmt_mispredict(c_mp),
        .cmt_mispred_pc(C_MPC), .cmt_taken(1'b1), .rob_squashing(rob),
        .dec_squash(d_sq), .dec_redirect_pc(D_PC), .dec_mispredict(d_mp),
        .dec_mispred_pc(D_MPC), .dec_taken(1'b0),
        .stall_decode(s_dec), .stall_rename(s_ren), .stall_exec(s_exe),
        .stall_commit(s_cmt), .acc_miss(a_miss), .acc_fault(a_flt),
        .miss_done(m_done), .status(status), .fetch_en(fetch_en),
        .acc_req(acc_req), .deliver(deliver), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .redir_npc(redir_npc), .miss_cancel(miss_cancel),
        .upd_dir_valid(upd_dir_valid), .upd_dir_pc(upd_dir_pc),
        .upd_dir_taken(upd_dir_taken), .upd_tgt_valid(upd_tgt_valid),
        .upd_tgt_pc(upd_tgt_pc), .upd_tgt_addr(upd_tgt_addr)
    );

    // Expected values for one evaluated cycle.
    int          e_nxt;
    bit          e_fe, e_ar, e_dl, e_rv, e_cn, e_uv, e_utk;
    logic [AW-1:0] e_rpc, e_upc, e_utgt;
    string       t_st, t_up;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        c_sq = 0; c_mp = 0; rob = 0; d_sq = 0; d_mp = 0;
        s_dec = 0; s_ren = 0; s_exe = 0; s_cmt = 0;
        a_miss = 0; a_flt = 0; m_done = 0;
    endtask

    // Expected behaviour from the priority order in the requirements.
    task automatic model(input int s);
        bit stall;
        stall = s_dec | s_ren | s_exe | s_cmt;
        e_nxt = s; e_fe = 0; e_ar = 0; e_dl = 0; e_rv = 0; e_cn = 0;
        e_uv = 0; e_utk = 0; e_rpc = '0; e_upc = '0; e_utgt = '0;
        t_st = "R10"; t_up = "R5";
        if (c_sq) begin
            e_nxt = 3; e_rv = 1; e_rpc = C_PC; e_cn = (s == 4);
            t_st = d_sq ? "R12" : "R2";
            if (c_mp) begin
                e_uv = 1; e_upc = C_MPC; e_utk = 1; e_utgt = C_PC;
                t_up = d_sq ? "R12" : "R3";
            end
        end else if (rob) begin
            e_nxt = 3; t_st = "R4";
        end else begin
            if (d_sq && d_mp) begin
                e_uv = 1; e_upc = D_MPC; e_utk = 0; e_utgt = D_PC;
            end
            if (d_sq && s != 3) begin
                e_nxt = 3; e_rv = 1; e_rpc = D_PC; e_cn = (s == 4); t_st = "R5";
            end else if (stall) begin
                e_nxt = 2; t_st = "R6";
            end else if (s == 2 || s == 3) begin
                e_nxt = 1; t_st = "R7";
            end else if (s == 4) begin
                e_nxt = m_done ? 5 : 4; t_st = "R8";
            end else if (s == 5) begin
                e_fe = 1; e_dl = 1; e_nxt = 1; t_st = "R9";
            end else begin
                e_fe = 1; e_ar = 1;
                if (a_flt) e_nxt = 2;
                else if (a_miss) e_nxt = 4;
                else begin e_nxt = 1; e_dl = 1; end
                if (m_done) t_st = "R8";
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk); clear_in(); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    // Walk the design from Idle into state st; ends on a falling edge.
    task automatic goto_state(input int st);
        case (st)
            1: begin @(negedge clk); end
            2: begin s_dec = 1; @(negedge clk); s_dec = 0; end
            3: begin rob = 1; @(negedge clk); rob = 0; end
            4: begin a_miss = 1; @(negedge clk); a_miss = 0; end
            5: begin a_miss = 1; @(negedge clk); a_miss = 0;
                     m_done = 1; @(negedge clk); m_done = 0; end
            default: ;
        endcase
    endtask

    task automatic run_case(input int st, input int v);
        do_reset();
        goto_state(st);
        chk(status == 3'(st), "R10", "setup state", AW'(status), AW'(st));
        c_sq = v[0]; c_mp = v[1]; rob = v[2]; d_sq = v[3]; d_mp = v[4];
        if (v[5]) begin
            case (v[7:6])
                2'd0: s_dec = 1;
                2'd1: s_ren = 1;
                2'd2: s_exe = 1;
                default: s_cmt = 1;
            endcase
        end
        m_done = v[8]; a_miss = v[9]; a_flt = v[10];
        model(st);
        #1;
        chk(fetch_en == e_fe, t_st, "fetch_en", AW'(fetch_en), AW'(e_fe));
        chk(acc_req == e_ar, t_st, "acc_req", AW'(acc_req), AW'(e_ar));
        chk(deliver == e_dl, t_st, "deliver", AW'(deliver), AW'(e_dl));
        @(posedge clk); #1;
        chk(status == 3'(e_nxt), t_st, "status", AW'(status), AW'(e_nxt));
        chk(redir_valid == e_rv, t_st, "redir_valid", AW'(redir_valid), AW'(e_rv));
        if (e_rv) begin
            chk(redir_pc == e_rpc, t_st, "redir_pc", redir_pc, e_rpc);
            chk(redir_npc == e_rpc + IB, t_st, "redir_npc", redir_npc, e_rpc + IB);
        end
        chk(miss_cancel == e_cn, "R11", "miss_cancel", AW'(miss_cancel), AW'(e_cn));
        chk(upd_dir_valid == e_uv, t_up, "upd_dir_valid", AW'(upd_dir_valid), AW'(e_uv));
        chk(upd_tgt_valid == e_uv, t_up, "upd_tgt_valid", AW'(upd_tgt_valid), AW'(e_uv));
        if (e_uv) begin
            chk(upd_dir_pc == e_upc, t_up, "upd_dir_pc", upd_dir_pc, e_upc);
            chk(upd_dir_taken == e_utk, t_up, "upd_dir_taken", AW'(upd_dir_taken), AW'(e_utk));
            chk(upd_tgt_pc == e_upc, t_up, "upd_tgt_pc", upd_tgt_pc, e_upc);
            chk(upd_tgt_addr == e_utgt, t_up, "upd_tgt_addr", upd_tgt_addr, e_utgt);
        end
        @(negedge clk); clear_in();
        #1;
        if (e_cn) begin
            // cancel must last exactly one cycle (R11)
            @(posedge clk); #1;
            chk(miss_cancel == 0, "R11", "cancel width", AW'(miss_cancel), '0);
        end
    endtask

    initial begin
        // R1: reset dominates even with active inputs.
        c_sq = 1; c_mp = 1; s_dec = 1;
        repeat (2) @(posedge clk);
        #1;
        chk(status == 3'd0, "R1", "reset status", AW'(status), '0);
        chk(redir_valid == 0, "R1", "reset redirect", AW'(redir_valid), '0);
        chk(upd_dir_valid == 0 && upd_tgt_valid == 0, "R1", "reset updates",
            AW'({upd_dir_valid, upd_tgt_valid}), '0);
        chk(miss_cancel == 0, "R1", "reset cancel", AW'(miss_cancel), '0);
        for (int st = 0; st < 6; st++) begin
            for (int v = 0; v < 2048; v++) begin
                run_case(st, v);
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

endmodule